// File: doc/BRIEF.md
# Per-Subpage ECC Status Evaluator

This block judges whether a page that the flash controller has just read holds an error the ECC engine could not correct. A one-cycle check strobe captures the controller's ECC status word and a format select. The block then evaluates the captured word and returns a registered pass/fail verdict. On a failure it also returns the index of the first subpage that failed.

In the packed format, the status word holds one 4-bit error count per 512-byte subpage. The block scans these counts one per clock, starting at subpage 0, and stops at the first count that exceeds the correction limit. That limit is fixed at elaboration from the spare bytes available to each subpage. In the older format, the word holds two status fields. A failure is flagged when either field carries the code 2, and the verdict comes after a single evaluation cycle.

The request side is a plain strobe with no handshake. A strobe is accepted only while the block is idle, and a strobe during a scan is dropped. The result side is a one-cycle pulse with no back-pressure. The consumer must take the verdict in the cycle it is flagged.

Top module: `ecc_page_judge`

## Requirements
- R1: While reset is held and after its release, `res_valid`, `res_fail` and `res_idx` are all 0.
- R2: In packed mode, subpage j's error count is `ecc_word[4j+3:4j]`, with subpage 0 in the least-significant nibble. Exactly SUBPAGES nibbles are checked.
- R3: The correction limit is 8 when SPARE_BYTES/SUBPAGES is greater than 16, and 4 otherwise. A value of exactly 16 gives 4.
- R4: In packed mode, the page fails if and only if some checked nibble is strictly greater than the limit. A nibble equal to the limit passes.
- R5: Take the edge that accepts the strobe as edge 1. Subpage j is evaluated at edge j+2. The result appears after edge 2+j for a failure at subpage j, after edge SUBPAGES+1 for a pass, and after edge 2 in legacy mode.
- R6: Each accepted strobe produces exactly one `res_valid` pulse, and that pulse lasts one cycle.
- R7: On a packed failure, `res_idx` is the lowest failing subpage. On a pass, and on a legacy failure, `res_idx` is 0.
- R8: A strobe that arrives while an evaluation is in progress is ignored. It neither adds a result nor replaces the captured word or mode.
- R9: With `mode_legacy`=1 at the strobe, the page fails if and only if `ecc_word[1:0]`==2 or `ecc_word[W-1:2]`==2. The nibble limit plays no part.
- R10: `ecc_word` and `mode_legacy` are sampled only at the accepting edge. Their later changes do not affect the verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| chk_strobe | input | 1 | Check request; accepted only while idle |
| mode_legacy | input | 1 | 1 selects the two-field format, 0 selects the packed-nibble format |
| ecc_word | input | 4*SUBPAGES | ECC status word from the controller |
| res_valid | output | 1 | One-cycle result pulse |
| res_fail | output | 1 | 1 when the page is uncorrectable; meaningful with `res_valid` |
| res_idx | output | max(1,clog2(SUBPAGES)) | First failing subpage, or 0 |

## Verification
The bench builds two copies of the block side by side, both with four subpages. One copy has 64 spare bytes, which puts it exactly on the 16-bytes-per-subpage boundary with a limit of 4. The other has 128 spare bytes and a limit of 8. Between them they cover both branches of the limit choice and the strict-greater comparison on each. With four subpages the 16-bit word is small enough to sweep every nibble value at every position, and to cover 1024 legacy codes that include every value of the upper field through 255. Every packed and legacy scan latency, including the longest, then falls inside a short observation window.

// File: rtl/ecc_eval_pkg.sv
package ecc_eval_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_EVAL = 1'b1
  } eval_state_e;

  function automatic int unsigned corr_limit(input int unsigned spare_bytes,
                                              input int unsigned subpages);
    int unsigned per_sub;
    per_sub = spare_bytes / subpages;
    return (per_sub > 16) ? 8 : 4;
  endfunction

  function automatic int unsigned idx_width(input int unsigned subpages);
    return (subpages > 1) ? $clog2(subpages) : 1;
  endfunction

endpackage

// File: rtl/ecc_limit_sel.sv
module ecc_limit_sel #(
  parameter int unsigned SUBPAGES    = 4,
  parameter int unsigned SPARE_BYTES = 64
) (
  output logic [3:0] limit
);
  localparam int unsigned PER_SUB = SPARE_BYTES / SUBPAGES;

  generate
    if (PER_SUB > 16) begin : g_wide_spare
      assign limit = 4'd8;
    end else begin : g_narrow_spare
      assign limit = 4'd4;
    end
  endgenerate

endmodule

// File: rtl/ecc_nibble_cmp.sv
module ecc_nibble_cmp #(
  parameter int unsigned SUBPAGES = 4,
  parameter int unsigned STW      = 4 * SUBPAGES,
  parameter int unsigned IDXW     = ecc_eval_pkg::idx_width(SUBPAGES)
) (
  input  logic [STW-1:0]  word,
  input  logic [IDXW-1:0] idx,
  input  logic [3:0]      limit,
  output logic            over,
  output logic            legacy_bad
);
  logic [3:0] nib [SUBPAGES];
  logic [3:0] cur;

  genvar g;
  generate
    for (g = 0; g < SUBPAGES; g++) begin : g_slice
      assign nib[g] = word[4*g +: 4];
    end
  endgenerate

  always_comb begin
    cur = 4'd0;
    for (int k = 0; k < SUBPAGES; k++) begin
      if (IDXW'(k) == idx) cur = nib[k];
    end
  end

  assign over = (cur > limit);

  logic [1:0]     low_fld;
  logic [STW-3:0] high_fld;
  assign low_fld    = word[1:0];
  assign high_fld   = word[STW-1:2];
  assign legacy_bad = (low_fld == 2'd2) || (high_fld == (STW-2)'(2));

endmodule

// File: rtl/ecc_scan_ctrl.sv
module ecc_scan_ctrl
  import ecc_eval_pkg::*;
#(
  parameter int unsigned SUBPAGES = 4,
  parameter int unsigned STW      = 4 * SUBPAGES,
  parameter int unsigned IDXW     = idx_width(SUBPAGES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chk_strobe,
  input  logic            mode_legacy,
  input  logic [STW-1:0]  ecc_word,
  input  logic            over,
  input  logic            legacy_bad,
  output logic [STW-1:0]  word_q,
  output logic [IDXW-1:0] idx_q,
  output logic            res_valid,
  output logic            res_fail,
  output logic [IDXW-1:0] res_idx
);
  localparam logic [IDXW-1:0] LAST = IDXW'(SUBPAGES - 1);

  eval_state_e state;
  logic        leg_q;
  logic        scanning;

  assign scanning = (state == ST_EVAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      word_q    <= '0;
      idx_q     <= '0;
      leg_q     <= 1'b0;
      res_valid <= 1'b0;
      res_fail  <= 1'b0;
      res_idx   <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (chk_strobe) begin
            word_q <= ecc_word;
            leg_q  <= mode_legacy;
            idx_q  <= '0;
            state  <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (leg_q) begin
            res_valid <= 1'b1;
            res_fail  <= legacy_bad;
            res_idx   <= '0;
            state     <= ST_IDLE;
          end else if (over) begin
            res_valid <= 1'b1;
            res_fail  <= 1'b1;
            res_idx   <= idx_q;
            state     <= ST_IDLE;
          end else if (idx_q == LAST) begin
            res_valid <= 1'b1;
            res_fail  <= 1'b0;
            res_idx   <= '0;
            state     <= ST_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_pass_idx_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_fail) |-> (res_idx == '0));

  p_word_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning && $past(scanning)) |-> $stable(word_q));

  p_scan_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning && !leg_q && !over && idx_q != LAST) |=> (idx_q == $past(idx_q) + 1'b1));

  p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (int'(res_idx) < SUBPAGES));

endmodule

// File: rtl/ecc_page_judge.sv
module ecc_page_judge
  import ecc_eval_pkg::*;
#(
  parameter int unsigned SUBPAGES    = 4,
  parameter int unsigned SPARE_BYTES = 64,
  localparam int unsigned STW        = 4 * SUBPAGES,
  localparam int unsigned IDXW       = idx_width(SUBPAGES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            chk_strobe,
  input  logic            mode_legacy,
  input  logic [STW-1:0]  ecc_word,
  output logic            res_valid,
  output logic            res_fail,
  output logic [IDXW-1:0] res_idx
);
  logic [3:0]      limit;
  logic [STW-1:0]  word_q;
  logic [IDXW-1:0] idx_q;
  logic            over;
  logic            legacy_bad;

  ecc_limit_sel #(.SUBPAGES(SUBPAGES), .SPARE_BYTES(SPARE_BYTES)) u_limit (
    .limit(limit)
  );

  ecc_nibble_cmp #(.SUBPAGES(SUBPAGES), .STW(STW), .IDXW(IDXW)) u_cmp (
    .word      (word_q),
    .idx       (idx_q),
    .limit     (limit),
    .over      (over),
    .legacy_bad(legacy_bad)
  );

  ecc_scan_ctrl #(.SUBPAGES(SUBPAGES), .STW(STW), .IDXW(IDXW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .chk_strobe (chk_strobe),
    .mode_legacy(mode_legacy),
    .ecc_word   (ecc_word),
    .over       (over),
    .legacy_bad (legacy_bad),
    .word_q     (word_q),
    .idx_q      (idx_q),
    .res_valid  (res_valid),
    .res_fail   (res_fail),
    .res_idx    (res_idx)
  );

endmodule

// File: tb/test_ecc_page_judge.sv
module test_ecc_page_judge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chk_strobe = 1'b0;
  logic mode_legacy = 1'b0;
  logic [15:0] ecc_word = '0;
  logic va, fa, vb, fb;
  logic [1:0] ia, ib;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  // limit 4: 64/4 = 16 spare bytes per subpage (boundary, R3)
  ecc_page_judge #(.SUBPAGES(4), .SPARE_BYTES(64)) i_ecc_page_judge (
    .clk(clk), .rst_n(rst_n), .chk_strobe(chk_strobe), .mode_legacy(mode_legacy),
    .ecc_word(ecc_word), .res_valid(va), .res_fail(fa), .res_idx(ia));

  // limit 8: 128/4 = 32 spare bytes per subpage (R3)
  ecc_page_judge #(.SUBPAGES(4), .SPARE_BYTES(128)) i_ecc_page_judge_wide (
    .clk(clk), .rst_n(rst_n), .chk_strobe(chk_strobe), .mode_legacy(mode_legacy),
    .ecc_word(ecc_word), .res_valid(vb), .res_fail(fb), .res_idx(ib));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int first_bad(input logic [15:0] w, input int lim);
    for (int j = 0; j < 4; j++) if (int'(w[4*j +: 4]) > lim) return j;
    return -1;
  endfunction

  function automatic bit legacy_fail(input logic [15:0] w);
    return (w[1:0] == 2'd2) || (w[15:2] == 14'd2);
  endfunction

  task automatic expect_one(input string tag, input logic [15:0] w, input bit leg, input int lim,
                            input int cnt, input int lat, input int f, input int idx);
    int j;
    int ef;
    int ei;
    int el;
    if (leg) begin
      ef = legacy_fail(w); ei = 0; el = 2;
    end else begin
      j  = first_bad(w, lim);
      ef = (j >= 0) ? 1 : 0;
      ei = (j >= 0) ? j : 0;
      el = (j >= 0) ? 2 + j : 5;
    end
    chk({tag, " R6 pulse count"}, cnt, 1);
    chk({tag, " R5 latency"}, lat, el);
    if (leg) chk({tag, " R9 legacy verdict"}, f, ef);
    else     chk({tag, " R4 verdict"}, f, ef);
    chk({tag, " R7 index"}, idx, ei);
  endtask

  // Drives one request, scrambles inputs right after capture (R10),
  // optionally re-strobes during the scan (R8), and watches 10 cycles.
  task automatic run(input logic [15:0] w, input bit leg, input bit restrobe);
    int ca, cb, la, lb, rfa, rfb, xa, xb;
    ca = 0; cb = 0; la = 0; lb = 0; rfa = 0; rfb = 0; xa = 0; xb = 0;
    @(negedge clk);
    chk_strobe = 1'b1; ecc_word = w; mode_legacy = leg;
    @(negedge clk);
    chk_strobe = 1'b0; ecc_word = ~w; mode_legacy = ~leg;
    for (int n = 1; n <= 10; n++) begin
      if (va) begin ca++; la = n; rfa = fa; xa = ia; end
      if (vb) begin cb++; lb = n; rfb = fb; xb = ib; end
      @(negedge clk);
      chk_strobe = (restrobe && n == 1);
    end
    chk_strobe = 1'b0;
    expect_one("lim4", w, leg, 4, ca, la, rfa, xa);
    expect_one("lim8", w, leg, 8, cb, lb, rfb, xb);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", va | vb, 0);
    chk("R1 fail in reset", fa | fb, 0);
    chk("R1 idx in reset", ia | ib, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", va | vb, 0);
    chk("R1 idx after reset", ia | ib, 0);

    // R2/R4: every value at every nibble position, on two backgrounds
    for (int p = 0; p < 4; p++)
      for (int v = 0; v < 16; v++)
        for (int b = 0; b < 2; b++) begin
          logic [15:0] w;
          w = (b == 0) ? 16'h0000 : 16'h4444;
          w[4*p +: 4] = 4'(v);
          run(w, 1'b0, 1'b0);
        end

    // R7: multiple failing subpages, lowest reported
    run(16'hFFFF, 1'b0, 1'b0);
    run(16'h9950, 1'b0, 1'b0);
    run(16'h5900, 1'b0, 1'b0);

    // R2/R4: pseudo-random words
    lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      run(lf & 16'h7777 | ((k % 3 == 0) ? 16'h8000 >> (4 * (k % 4)) : 16'h0), 1'b0, 1'b0);
    end

    // R9: legacy codes covering upper field 0..255 and every low field
    for (int v = 0; v < 1024; v++) run(16'(v), 1'b1, 1'b0);
    run(16'h8002, 1'b1, 1'b0);
    run(16'h0009, 1'b1, 1'b0);

    // R8: re-strobe while scanning is ignored (first word all-pass)
    run(16'h0000, 1'b0, 1'b1);
    run(16'h2400, 1'b0, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule